// File: doc/BRIEF.md
# Edge-to-Pulse Encoder with Level Refresh

This block is the sending side of a channel that carries a logic level as a stream of short strobes instead of a steady signal. It samples one asynchronous data input. A rising input produces a single strobe on a "set" line, and a falling input produces a single strobe on a separate "reset" line. Each strobe lasts one clock cycle. A receiver that holds a bistable latch can rebuild the level from these strobes.

Edges alone do not fix the receiver's state if a strobe is lost, or if the receiver starts after the input has already settled. For that case the block has a keep-alive mode. While this mode is on and the input has been quiet for a programmable number of cycles, the block re-sends a strobe that encodes the present level. It sends set when the input is high and reset when it is low, and it repeats this at the same interval for as long as the input stays quiet. The keep-alive enable is active low. Holding it high selects a low-power mode in which only real edges produce strobes.

Top module: `edge_pulse_tx`

## Requirements
- R1: A low-to-high change on `din` produces exactly one `set_pulse`. It appears on the third rising clock edge after the change is first sampled: two synchronizer stages, then the output register.
- R2: A high-to-low change on `din` produces exactly one `reset_pulse`, with the same latency as R1.
- R3: Every strobe is high for exactly one clock cycle. If `din` goes high for one cycle and then low again, the bench sees a set strobe followed in the next cycle by a reset strobe.
- R4: With keep-alive on (`refresh_en_n` = 0), once IDLE_CYCLES cycles pass after the last strobe with no input edge, a keep-alive strobe is sent. Later keep-alive strobes repeat every IDLE_CYCLES cycles.
- R5: A keep-alive strobe encodes the synchronized level. It is `set_pulse` when the level is 1 and `reset_pulse` when it is 0.
- R6: With `refresh_en_n` = 1, no keep-alive strobes are produced, however long the input stays quiet. Edges still produce strobes.
- R7: The idle count saturates while keep-alive is off. Turning keep-alive on after a quiet period of at least IDLE_CYCLES therefore sends a keep-alive strobe right away, on the third rising edge after the enable is first sampled low.
- R8: While `rst_n` is low, both strobes are low. The stored previous level clears to 0, so a `din` that is already high when reset is released produces one set strobe.
- R9: `set_pulse` and `reset_pulse` are never high in the same cycle. An input edge takes priority over a keep-alive strobe and restarts the idle interval, so the next keep-alive comes IDLE_CYCLES cycles after the edge strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 1 | Asynchronous data level to encode |
| refresh_en_n | input | 1 | Keep-alive enable, active low (asynchronous) |
| set_pulse | output | 1 | One-cycle strobe: rising edge, or keep-alive for a high level |
| reset_pulse | output | 1 | One-cycle strobe: falling edge, or keep-alive for a low level |

## Verification
The embedded assertions check these properties on every cycle:
- the two strobes are never high together;
- each strobe lasts a single cycle;
- each detected edge is followed by the matching strobe;
- a keep-alive strobe matches the synchronized level;
- no strobe appears while keep-alive is off and no edge occurs;
- the idle counter stays within its bound.

Only the bench scenarios can show the timing from the input pins to the strobes. The same holds for the exact keep-alive period, the restart of that period on an edge, the immediate strobe after keep-alive is turned on late, and the set strobe that follows a reset released with the input high.

// File: rtl/epx_pkg.sv
// Package: epx_pkg
// Shared types for the edge-to-pulse encoder. Assumes nothing beyond
// a single clock domain for every module that imports it.
package epx_pkg;

    // Which strobe, if any, is sent in a cycle.
    typedef enum logic [1:0] {
        STROBE_NONE  = 2'b00,
        STROBE_SET   = 2'b01,
        STROBE_RESET = 2'b10
    } strobe_kind_e;

endpackage

// File: rtl/epx_sync.sv
// Module: epx_sync
// Multi-stage synchronizer for asynchronous level inputs. Each bit
// goes through STAGES flops. Assumes each input bit is a slowly
// changing level; buses whose bits must stay coherent are not
// supported. Synchronous active-low reset loads RESET_VAL.
module epx_sync #(
    parameter int unsigned      WIDTH     = 1,
    parameter int unsigned      STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage: capture the asynchronous input.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= RESET_VAL;
                else        chain[s] <= async_in;
            end
        end else begin : g_next
            // Later stages: move the value one flop along.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= RESET_VAL;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/epx_edge_detect.sv
// Module: epx_edge_detect
// Compares the synchronized level with its value one cycle earlier and
// flags rising and falling changes. Assumes the level is already
// synchronous. The stored level clears to 0 on reset, so a high level
// right after reset counts as a rising change.
module epx_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise,
    output logic fall
);

    logic level_prev;

    // Remember last cycle's level.
    always_ff @(posedge clk) begin
        if (!rst_n) level_prev <= 1'b0;
        else        level_prev <= level;
    end

    // Decode the direction of the change.
    always_comb begin
        rise = level & ~level_prev;
        fall = ~level & level_prev;
    end

endmodule

// File: rtl/epx_idle_timer.sv
// Module: epx_idle_timer
// Counts cycles since the last strobe. Raises expire when keep-alive is
// enabled and IDLE_CYCLES cycles have passed. The count clears on restart
// and on expiry. It saturates while disabled, so enabling keep-alive after a
// long quiet spell expires at once. Assumes IDLE_CYCLES >= 2.
module epx_idle_timer #(
    parameter int unsigned IDLE_CYCLES = 7000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic restart,
    output logic expire
);

    localparam int unsigned        CNT_W = $clog2(IDLE_CYCLES);
    localparam logic [CNT_W-1:0]   LAST  = CNT_W'(IDLE_CYCLES - 1);

    logic [CNT_W-1:0] count;

    // Expiry: keep-alive on, count at its last value, and no edge this cycle.
    always_comb begin
        expire = enable && (count == LAST) && !restart;
    end

    // Idle count: clears on any strobe, otherwise climbs to LAST and holds.
    always_ff @(posedge clk) begin
        if (!rst_n)                 count <= '0;
        else if (restart || expire) count <= '0;
        else if (count != LAST)     count <= count + CNT_W'(1);
    end

    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LAST);

    assert_expire_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (count == '0));

endmodule

// File: rtl/edge_pulse_tx.sv
// Module: edge_pulse_tx
// Sending side of a strobe-coded level channel. Synchronizes the data
// input and the active-low keep-alive enable. Turns rising and falling
// edges into one-cycle set and reset strobes. When keep-alive is on,
// re-sends a level-encoding strobe after IDLE_CYCLES quiet cycles.
// Assumes a single clock and synchronous active-low reset.
module edge_pulse_tx #(
    parameter int unsigned IDLE_CYCLES = 7000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic refresh_en_n,
    output logic set_pulse,
    output logic reset_pulse
);
    import epx_pkg::*;

    logic         level_s;
    logic         ka_off_s;
    logic         rise;
    logic         fall;
    logic         edge_seen;
    logic         fire;
    strobe_kind_e kind;

    // Data path synchronizer; resets low to match the cleared previous level.
    epx_sync #(
        .WIDTH     (1),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b0)
    ) u_sync_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (din),
        .sync_out (level_s)
    );

    // Enable synchronizer; resets high so keep-alive starts off.
    epx_sync #(
        .WIDTH     (1),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync_en (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (refresh_en_n),
        .sync_out (ka_off_s)
    );

    epx_edge_detect u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (level_s),
        .rise  (rise),
        .fall  (fall)
    );

    assign edge_seen = rise | fall;

    epx_idle_timer #(
        .IDLE_CYCLES (IDLE_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (~ka_off_s),
        .restart (edge_seen),
        .expire  (fire)
    );

    // Choose the strobe: edges first, keep-alive follows the level.
    always_comb begin
        kind = STROBE_NONE;
        if (rise)       kind = STROBE_SET;
        else if (fall)  kind = STROBE_RESET;
        else if (fire)  kind = level_s ? STROBE_SET : STROBE_RESET;
    end

    // Register the strobes so the outputs are glitch-free single-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_pulse   <= 1'b0;
            reset_pulse <= 1'b0;
        end else begin
            set_pulse   <= (kind == STROBE_SET);
            reset_pulse <= (kind == STROBE_RESET);
        end
    end

    assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_pulse && reset_pulse));

    assert_set_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        set_pulse |=> !set_pulse);

    assert_reset_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reset_pulse |=> !reset_pulse);

    assert_rise_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> set_pulse);

    assert_fall_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> reset_pulse);

    assert_refresh_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (set_pulse == $past(level_s)) && (reset_pulse == !$past(level_s)));

    assert_quiet_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ka_off_s && !edge_seen) |=> !(set_pulse || reset_pulse));

endmodule

// File: tb/edge_pulse_tx_tb.sv
module edge_pulse_tx_tb;

    localparam int IDLE = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic din = 1'b0;
    logic refresh_en_n = 1'b1;
    logic set_pulse;
    logic reset_pulse;

    int checks = 0;
    int failures = 0;
    int both_high = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    edge_pulse_tx #(.IDLE_CYCLES(IDLE), .SYNC_STAGES(2)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .din          (din),
        .refresh_en_n (refresh_en_n),
        .set_pulse    (set_pulse),
        .reset_pulse  (reset_pulse)
    );

    // Watch for both strobes high together (R9).
    always @(negedge clk) if (rst_n && set_pulse && reset_pulse) both_high++;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Wait for the next strobe; n = negedges waited, 0-based strobes returned.
    task automatic wait_strobe(input int limit, output int n, output logic s, output logic r);
        n = 0; s = 0; r = 0;
        while (n < limit) begin
            @(negedge clk);
            n++;
            if (set_pulse || reset_pulse) begin
                s = set_pulse; r = reset_pulse;
                return;
            end
        end
    endtask

    task automatic count_strobes(input int cycles, output int cnt);
        cnt = 0;
        repeat (cycles) begin
            @(negedge clk);
            if (set_pulse || reset_pulse) cnt++;
        end
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0; din = 1'b0; refresh_en_n = 1'b1;
        step(4);
        check(!set_pulse && !reset_pulse, "R8 strobes low in reset", {set_pulse, reset_pulse}, 0);
        rst_n = 1'b1;
        step(5);
        check(!set_pulse && !reset_pulse, "R8 quiet after release with din low", {set_pulse, reset_pulse}, 0);
    endtask

    task automatic t_rise();
        din = 1'b1;
        step(2);
        check(!set_pulse, "R1 no early set", set_pulse, 0);
        step(1);
        check(set_pulse && !reset_pulse, "R1 set on third edge", {set_pulse, reset_pulse}, 2);
        step(1);
        check(!set_pulse, "R3 set lasts one cycle", set_pulse, 0);
    endtask

    task automatic t_fall();
        din = 1'b0;
        step(3);
        check(reset_pulse && !set_pulse, "R2 reset on third edge", {set_pulse, reset_pulse}, 1);
        step(1);
        check(!reset_pulse, "R3 reset lasts one cycle", reset_pulse, 0);
    endtask

    task automatic t_low_power();
        int cnt;
        count_strobes(5 * IDLE, cnt);
        check(cnt == 0, "R6 no keep-alive when disabled", cnt, 0);
    endtask

    task automatic t_short_pulse();
        din = 1'b1; step(1); din = 1'b0;
        step(2);
        check(set_pulse && !reset_pulse, "R3 short high gives set", {set_pulse, reset_pulse}, 2);
        step(1);
        check(reset_pulse && !set_pulse, "R3 then reset next cycle", {set_pulse, reset_pulse}, 1);
        step(1);
        check(!set_pulse && !reset_pulse, "R3 then idle", {set_pulse, reset_pulse}, 0);
    endtask

    task automatic t_enable_late();
        int n; logic s, r;
        refresh_en_n = 1'b0;
        step(3);
        check(reset_pulse && !set_pulse, "R7 immediate keep-alive, low level (R5)", {set_pulse, reset_pulse}, 1);
        wait_strobe(3 * IDLE, n, s, r);
        check(n == IDLE, "R4 keep-alive period", n, IDLE);
        check(r && !s, "R5 keep-alive low gives reset", {s, r}, 1);
        wait_strobe(3 * IDLE, n, s, r);
        check(n == IDLE, "R4 keep-alive repeats", n, IDLE);
    endtask

    task automatic t_edge_restart();
        int n; logic s, r;
        step(IDLE / 2);
        din = 1'b1;
        wait_strobe(10, n, s, r);
        check(n == 3 && s && !r, "R9 edge beats keep-alive, set strobe", n, 3);
        wait_strobe(3 * IDLE, n, s, r);
        check(n == IDLE, "R9 edge restarts idle interval", n, IDLE);
        check(s && !r, "R5 keep-alive high gives set", {s, r}, 2);
    endtask

    task automatic t_disable_again();
        int cnt;
        refresh_en_n = 1'b1;
        count_strobes(4 * IDLE, cnt);
        check(cnt == 0, "R6 keep-alive stops when disabled", cnt, 0);
    endtask

    task automatic t_reset_high();
        int n; logic s, r;
        rst_n = 1'b0; din = 1'b1; refresh_en_n = 1'b1;
        step(3);
        rst_n = 1'b1;
        wait_strobe(10, n, s, r);
        check(n == 3 && s && !r, "R8 high input after reset gives set", n, 3);
        wait_strobe(3 * IDLE, n, s, r);
        check(n == 3 * IDLE, "R8 only one set after reset", n, 3 * IDLE);
    endtask

    initial begin
        t_reset_state();
        t_rise();
        t_low_power();
        t_fall();
        t_short_pulse();
        t_low_power();
        t_enable_late();
        t_edge_restart();
        t_disable_again();
        t_reset_high();
        check(both_high == 0, "R9 strobes never together", both_high, 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule